// File: doc/BRIEF.md
# I2S Stereo Transmit Channel

This block is a single stereo transmit lane for an I2S controller. Software or a DMA engine pushes left/right sample pairs into a small FIFO. The channel serialises each pair onto one serial data line. It uses a bit-tick strobe and a word-select level that a separate clock generator supplies in the same clock domain. Sample resolution is programmable. Only the valid bits are sent, MSB first, and the rest of each slot is padded with zeros. When the FIFO is empty, zeros go out.

A small register port holds the lane controls: a lane enable, the resolution code, a FIFO threshold, a flush command, an interrupt mask, the live status and a clear-on-read overrun register. The interrupt output flags two conditions. The first is that the FIFO has fallen to the programmed threshold. The second is that a push arrived while the FIFO was full. Several of these lanes can sit side by side behind one controller, and each is an independent instance.

Top module: `i2s_tx_channel`

## Requirements
- R1: After reset, sdOut and irq are 0. Register reads return: address 0 (lane enable) 0, address 1 (resolution) 5, address 2 (threshold) DEPTH/2-1, address 4 (mask) 0x30, address 5 (status) 0x10 and address 6 (overrun clear) 0.
- R2: The resolution code at address 1 bits [2:0] selects the number of valid bits: 2 gives 16, 4 gives 24, and any other code gives 32. The low valid bits of each sample go out MSB first, followed by zeros to the end of the slot. Sample bits above the resolution are ignored.
- R3: Status bit 4 (FIFO low) at address 5 is 1 exactly when the number of stored pairs is less than or equal to the threshold field at address 2.
- R4: The FIFO holds DEPTH = 2^(1+DEPTH_CODE) pairs. A push while DEPTH pairs are held is dropped and sets status bit 5 (overrun). A read of address 6 returns the overrun flag in bit 0 and clears it.
- R5: Address 4 bits 4 and 5 mask the FIFO-low and overrun conditions, and a 1 masks. irq is the OR of the status bits whose mask bit is 0.
- R6: Writing 1 to bit 0 of address 3 empties the FIFO. Later frames then carry zeros until new pairs are pushed.
- R7: The lane transmits and pops pairs only while address 0 bit 0 and blockTxEn are both 1. Otherwise sdOut stays 0 and stored pairs are kept.
- R8: A word starts at the first bitTick at which wsIn differs from its value at the previous bitTick. wsIn = 0 starts the left word and pops one pair; wsIn = 1 starts the right word of that same pair. sdOut takes its new bit at the clock edge where bitTick is high.
- R9: If the FIFO is empty when a left word starts, both words of that frame are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (address 6 read clears the overrun flag) |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| pushEn | input | 1 | Push one sample pair into the FIFO |
| pushLeft | input | SAMPLE_W | Left sample, right-aligned |
| pushRight | input | SAMPLE_W | Right sample, right-aligned |
| blockTxEn | input | 1 | Controller-level transmit enable |
| bitTick | input | 1 | One-cycle strobe per serial bit |
| wsIn | input | 1 | Word select: 0 left, 1 right |
| sdOut | output | 1 | Serial data |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check these rules:
- The FIFO level never exceeds its depth.
- Pushes are accepted only with room in the FIFO.
- Pops happen only at a left-word start on a non-empty FIFO.
- A flush leaves the FIFO empty.
- The overrun flag sets on a push into a full FIFO and holds until the clearing read.
- An idle lane drives zero.

Some behaviours only the bench scenarios can show. These are the bit order and zero padding for each resolution code, the pairing of left and right words across a frame, the threshold boundary, and the dropping of the extra push. The bench also shows that a stored pair survives a disabled period intact.

// File: rtl/i2stx_pkg.sv
package i2stx_pkg;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_RES    = 3'd1,
    REG_THR    = 3'd2,
    REG_FLUSH  = 3'd3,
    REG_MASK   = 3'd4,
    REG_STAT   = 3'd5,
    REG_OVRCLR = 3'd6
  } regAddr_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic pushDo;
    logic popDo;
    logic flushDo;
    logic loadLeft;
    logic loadRight;
    logic shiftDo;
    logic idleClr;
  } txStrobes_t;

  // Resolution code to number of valid bits
  function automatic int resToBits(input logic [2:0] code);
    case (code)
      3'd2:    return 16;
      3'd4:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/i2stx_datapath.sv
module i2stx_datapath
  import i2stx_pkg::*;
#(
  parameter int SAMPLE_W   = 32,
  parameter int DEPTH_LOG2 = 3,
  localparam int DEPTH  = 1 << DEPTH_LOG2,
  localparam int LVL_W  = DEPTH_LOG2 + 1,
  localparam int BITS_W = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobes_t          st,
  input  logic [SAMPLE_W-1:0] pushLeft,
  input  logic [SAMPLE_W-1:0] pushRight,
  input  logic [BITS_W-1:0]   validBits,
  output logic [LVL_W-1:0]    level,
  output logic                sdOut
);

  logic [2*SAMPLE_W-1:0] mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wrPtr, rdPtr;
  logic [SAMPLE_W-1:0]   headLeft, headRight;
  logic [SAMPLE_W-1:0]   shifter, nextShift;
  logic [SAMPLE_W-1:0]   rightHold, nextHold;
  logic [BITS_W-1:0]     padBits;

  assign headLeft  = mem[rdPtr][2*SAMPLE_W-1:SAMPLE_W];
  assign headRight = mem[rdPtr][SAMPLE_W-1:0];
  assign padBits   = BITS_W'(SAMPLE_W) - validBits;

  // FIFO storage
  always_ff @(posedge clk) begin
    if (st.pushDo) mem[wrPtr] <= {pushLeft, pushRight};
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.flushDo) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (st.pushDo) wrPtr <= wrPtr + DEPTH_LOG2'(1);
      if (st.popDo)  rdPtr <= rdPtr + DEPTH_LOG2'(1);
      case ({st.pushDo, st.popDo})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  // Serialiser: MSB of shifter is the bit on the line
  always_comb begin
    nextShift = shifter;
    nextHold  = rightHold;
    if (st.idleClr) begin
      nextShift = '0;
      nextHold  = '0;
    end else if (st.loadLeft) begin
      nextShift = st.popDo ? (headLeft << padBits) : '0;
      nextHold  = st.popDo ? headRight : '0;
    end else if (st.loadRight) begin
      nextShift = rightHold << padBits;
    end else if (st.shiftDo) begin
      nextShift = shifter << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shifter   <= '0;
      rightHold <= '0;
      sdOut     <= 1'b0;
    end else begin
      shifter   <= nextShift;
      rightHold <= nextHold;
      sdOut     <= nextShift[SAMPLE_W-1];
    end
  end

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  p_push_room_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.pushDo |-> level < LVL_W'(DEPTH));

  p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.popDo |-> level != '0);

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.flushDo |=> level == '0);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.idleClr |=> !sdOut);

endmodule

// File: rtl/i2stx_control.sv
module i2stx_control
  import i2stx_pkg::*;
#(
  parameter int SAMPLE_W   = 32,
  parameter int DEPTH_LOG2 = 3,
  parameter int REG_W      = 32,
  localparam int DEPTH  = 1 << DEPTH_LOG2,
  localparam int LVL_W  = DEPTH_LOG2 + 1,
  localparam int BITS_W = $clog2(SAMPLE_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              pushEn,
  input  logic              bitTick,
  input  logic              wsIn,
  input  logic              blockTxEn,
  input  logic [LVL_W-1:0]  level,
  output txStrobes_t        st,
  output logic [BITS_W-1:0] validBits,
  output logic              irq
);

  logic             chanEn;
  logic [2:0]       resCode;
  logic [LVL_W-1:0] thrField;
  logic [1:0]       maskBits;
  logic             ovrFlag;
  logic             wsLast;
  logic             fifoFull, lowStat, flushNow, txActive, wsEdge;
  logic             ovrSet, ovrRdClr;
  logic [1:0]       statusVec;
  logic             unusedWr;

  assign unusedWr  = ^regWrData;
  assign fifoFull  = (level == LVL_W'(DEPTH));
  assign lowStat   = (level <= thrField);
  assign flushNow  = regWrEn && (regAddr == REG_FLUSH) && regWrData[0];
  assign txActive  = chanEn && blockTxEn;
  assign wsEdge    = bitTick && (wsIn != wsLast);
  assign ovrSet    = pushEn && fifoFull && !flushNow;
  assign ovrRdClr  = regRdEn && (regAddr == REG_OVRCLR);
  assign statusVec = {ovrFlag, lowStat};
  assign validBits = BITS_W'(resToBits(resCode));
  assign irq       = |(statusVec & ~maskBits);

  always_comb begin
    st.flushDo   = flushNow;
    st.pushDo    = pushEn && !fifoFull && !flushNow;
    st.idleClr   = !txActive;
    st.loadLeft  = txActive && wsEdge && !wsIn;
    st.loadRight = txActive && wsEdge && wsIn;
    st.shiftDo   = txActive && bitTick && !wsEdge;
    st.popDo     = txActive && wsEdge && !wsIn && (level != '0) && !flushNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEn   <= 1'b0;
      resCode  <= 3'd5;
      thrField <= LVL_W'(DEPTH / 2 - 1);
      maskBits <= 2'b11;
      ovrFlag  <= 1'b0;
      wsLast   <= 1'b1;
    end else begin
      if (bitTick) wsLast <= wsIn;
      if (ovrSet)        ovrFlag <= 1'b1;
      else if (ovrRdClr) ovrFlag <= 1'b0;
      if (regWrEn) begin
        case (regAddr)
          REG_CTRL: chanEn   <= regWrData[0];
          REG_RES:  resCode  <= regWrData[2:0];
          REG_THR:  thrField <= regWrData[LVL_W-1:0];
          REG_MASK: maskBits <= regWrData[5:4];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      REG_CTRL:   regRdData = REG_W'(chanEn);
      REG_RES:    regRdData = REG_W'(resCode);
      REG_THR:    regRdData = REG_W'(thrField);
      REG_MASK:   regRdData = REG_W'({maskBits, 4'b0});
      REG_STAT:   regRdData = REG_W'({statusVec, 4'b0});
      REG_OVRCLR: regRdData = REG_W'(ovrFlag);
      default:    regRdData = '0;
    endcase
  end

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && fifoFull && !flushNow) |=> ovrFlag);

  p_ovr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !ovrRdClr) |=> ovrFlag);

  p_pop_at_left_r8: assert property (@(posedge clk) disable iff (!rstN)
    st.popDo |-> (bitTick && !wsIn && txActive));

  p_no_pop_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !blockTxEn |-> !st.popDo);

endmodule

// File: rtl/i2s_tx_channel.sv
module i2s_tx_channel
  import i2stx_pkg::*;
#(
  parameter int SAMPLE_W   = 32,
  parameter int DEPTH_CODE = 2,
  parameter int REG_W      = 32,
  localparam int DEPTH_LOG2 = DEPTH_CODE + 1,
  localparam int LVL_W      = DEPTH_LOG2 + 1,
  localparam int BITS_W     = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [2:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  input  logic                pushEn,
  input  logic [SAMPLE_W-1:0] pushLeft,
  input  logic [SAMPLE_W-1:0] pushRight,
  input  logic                blockTxEn,
  input  logic                bitTick,
  input  logic                wsIn,
  output logic                sdOut,
  output logic                irq
);

  txStrobes_t        strobes;
  logic [LVL_W-1:0]  fifoLevel;
  logic [BITS_W-1:0] validBits;

  i2stx_control #(.SAMPLE_W(SAMPLE_W), .DEPTH_LOG2(DEPTH_LOG2), .REG_W(REG_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .pushEn(pushEn), .bitTick(bitTick), .wsIn(wsIn), .blockTxEn(blockTxEn),
    .level(fifoLevel), .st(strobes), .validBits(validBits), .irq(irq)
  );

  i2stx_datapath #(.SAMPLE_W(SAMPLE_W), .DEPTH_LOG2(DEPTH_LOG2)) dp_i (
    .clk(clk), .rstN(rstN), .st(strobes),
    .pushLeft(pushLeft), .pushRight(pushRight), .validBits(validBits),
    .level(fifoLevel), .sdOut(sdOut)
  );

endmodule

// File: tb/i2s_tx_channel_tb_top.sv
`timescale 1ns/1ps
module i2s_tx_channel_tb_top;

  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        pushEn = 1'b0;
  logic [31:0] pushLeft = '0, pushRight = '0;
  logic        blockTxEn = 1'b0, bitTick = 1'b0, wsIn = 1'b1;
  logic        sdOut, irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  i2s_tx_channel dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .pushEn(pushEn), .pushLeft(pushLeft), .pushRight(pushRight),
    .blockTxEn(blockTxEn), .bitTick(bitTick), .wsIn(wsIn),
    .sdOut(sdOut), .irq(irq)
  );

  typedef struct packed {
    logic [2:0]  code;
    logic [31:0] inL;
    logic [31:0] inR;
    logic [31:0] expL;
    logic [31:0] expR;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{3'd5, 32'hA5C30F1E, 32'h12345678, 32'hA5C30F1E, 32'h12345678},
    '{3'd2, 32'hFFFFBEEF, 32'h00008001, 32'hBEEF0000, 32'h80010000},
    '{3'd4, 32'h00CAFE12, 32'hFF800001, 32'hCAFE1200, 32'h80000100},
    '{3'd3, 32'h80000001, 32'h7FFFFFFE, 32'h80000001, 32'h7FFFFFFE}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pushPair(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    pushEn = 1'b1; pushLeft = l; pushRight = r;
    @(negedge clk);
    pushEn = 1'b0;
  endtask

  task automatic sendFrame(output logic [31:0] gotL, output logic [31:0] gotR);
    gotL = '0; gotR = '0;
    for (int b = 0; b < 64; b++) begin
      @(negedge clk);
      wsIn = (b >= 32); bitTick = 1'b1;
      @(negedge clk);
      bitTick = 1'b0;
      if (b < 32) gotL = {gotL[30:0], sdOut};
      else        gotR = {gotR[30:0], sdOut};
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, gl, gr;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 sdOut", 32'(sdOut), 32'd0);
    check("R1 irq", 32'(irq), 32'd0);
    regRead(3'd0, rd); check("R1 lane enable", rd, 32'd0);
    regRead(3'd1, rd); check("R1 resolution", rd, 32'd5);
    regRead(3'd2, rd); check("R1 threshold", rd, 32'(DEPTH / 2 - 1));
    regRead(3'd4, rd); check("R1 mask", rd, 32'h30);
    regRead(3'd5, rd); check("R1 status", rd, 32'h10);
    regRead(3'd6, rd); check("R1 overrun", rd, 32'd0);

    blockTxEn = 1'b1;
    regWrite(3'd0, 32'd1);

    // R2 / R8: table of resolution vectors
    for (int i = 0; i < 4; i++) begin
      regWrite(3'd1, 32'(VECS[i].code));
      pushPair(VECS[i].inL, VECS[i].inR);
      sendFrame(gl, gr);
      check($sformatf("R2 R8 vec%0d left", i), gl, VECS[i].expL);
      check($sformatf("R2 R8 vec%0d right", i), gr, VECS[i].expR);
    end

    // R9 empty FIFO gives a zero frame
    sendFrame(gl, gr);
    check("R9 empty left", gl, 32'd0);
    check("R9 empty right", gr, 32'd0);

    // R3 threshold boundary
    regWrite(3'd2, 32'd3);
    for (int i = 0; i < 4; i++) pushPair(32'hC0DE0000 + 32'(i), 32'hC0DE1000 + 32'(i));
    regRead(3'd5, rd); check("R3 level 4 above thr 3", rd, 32'h00);
    regWrite(3'd2, 32'd4);
    regRead(3'd5, rd); check("R3 level 4 equal thr 4", rd, 32'h10);

    // R5 masking
    regWrite(3'd4, 32'h20);
    @(negedge clk); check("R5 low unmasked irq", 32'(irq), 32'd1);
    regWrite(3'd4, 32'h10);
    @(negedge clk); check("R5 low masked irq", 32'(irq), 32'd0);
    regWrite(3'd4, 32'h30);

    // R6 flush
    regWrite(3'd2, 32'd0);
    regRead(3'd5, rd); check("R6 before flush", rd, 32'h00);
    regWrite(3'd3, 32'd1);
    regRead(3'd5, rd); check("R6 after flush", rd, 32'h10);
    sendFrame(gl, gr);
    check("R6 flushed left", gl, 32'd0);
    check("R6 flushed right", gr, 32'd0);

    // R4 depth and overrun
    regWrite(3'd1, 32'd5);
    for (int i = 0; i < DEPTH; i++) pushPair(32'h1000 + 32'(i), 32'h2000 + 32'(i));
    regRead(3'd5, rd); check("R4 full no overrun", rd, 32'h00);
    pushPair(32'hBAD0BAD0, 32'hBAD1BAD1);
    regRead(3'd5, rd); check("R4 overrun status", rd, 32'h20);
    regWrite(3'd4, 32'h10);
    @(negedge clk); check("R4 R5 overrun irq", 32'(irq), 32'd1);
    regRead(3'd6, rd); check("R4 clear read value", rd, 32'd1);
    regRead(3'd5, rd); check("R4 status after clear", rd, 32'h00);
    @(negedge clk); check("R4 irq after clear", 32'(irq), 32'd0);
    regRead(3'd6, rd); check("R4 second read", rd, 32'd0);
    for (int i = 0; i < DEPTH; i++) begin
      sendFrame(gl, gr);
      check($sformatf("R4 drain %0d left", i), gl, 32'h1000 + 32'(i));
      check($sformatf("R4 drain %0d right", i), gr, 32'h2000 + 32'(i));
    end
    sendFrame(gl, gr);
    check("R4 dropped push left", gl, 32'd0);
    check("R4 dropped push right", gr, 32'd0);
    regWrite(3'd4, 32'h30);

    // R7 enables
    blockTxEn = 1'b0;
    pushPair(32'hDEAD0001, 32'hDEAD0002);
    sendFrame(gl, gr);
    check("R7 block off left", gl, 32'd0);
    check("R7 block off right", gr, 32'd0);
    blockTxEn = 1'b1;
    regWrite(3'd0, 32'd0);
    sendFrame(gl, gr);
    check("R7 lane off left", gl, 32'd0);
    check("R7 lane off right", gr, 32'd0);
    regWrite(3'd0, 32'd1);
    sendFrame(gl, gr);
    check("R7 kept pair left", gl, 32'hDEAD0001);
    check("R7 kept pair right", gr, 32'hDEAD0002);
    regRead(3'd5, rd); check("R7 R3 drained status", rd, 32'h10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule